// File: doc/BRIEF.md
# Flash Channel Request Decoder

This block turns a received flash-access request, delivered as a stream of 32-bit words, into one decoded request for the flash engine behind it. The first word of a packet is marked by a start flag. It carries the cycle type, a 4-bit tag and a 12-bit length spread over two bytes. The second word carries the target address with its bytes in network order. Write requests then carry their data words. The block rebuilds the length, corrects the address byte order and classifies the request. It parks write data in a small word store.

The decoded request is presented with a valid/ready handshake and held until the consumer takes it. For writes, the stored data words then follow on a separate payload stream with a last-word flag. While a request or its payload is outstanding, the input side is stalled. A write that claims more data than the store can hold is rejected with a one-cycle flag and is never forwarded.

Top module: `flash_req_decoder`

## Requirements
- R1: The first word of a packet is decoded by bit position. Bits [15:8] are the cycle type (`req_type`) and bits [23:20] are the tag. The length is bits [19:16] as its upper four bits joined with bits [31:24] as its lower eight. `req_kind` is taken from the low nibble of the type: 0 gives 0 (read), 1 gives 1 (write), 2 gives 2 (erase), and any other value gives 3 (other). Bits [7:0] of the first word are ignored.
- R2: A read whose encoded length is zero is reported with `req_len` = 4096 on the 13-bit length output. A zero length on any other kind is reported as 0.
- R3: `req_addr` is the second word with its four bytes in reverse order: byte 0 of the word becomes bits [31:24].
- R4: For a write, ceil(length/4) data words follow the address word. The block collects them and reports that count on `req_pl_words`. Every other kind reports 0 on `req_pl_words` and presents its request right after the address word.
- R5: A write whose length needs more than MAX_PL_WORDS data words (more than 64 bytes by default) raises `req_malformed` for exactly one cycle after its first word is accepted. No request follows for it, and its remaining words are discarded.
- R6: While `req_valid` is high and `req_ready` is low, every request output holds its value and `in_ready` stays low.
- R7: After a write request is accepted, its data words appear on `pl_data` in arrival order. `pl_last` marks the final word, each word is held until `pl_ready`, and `in_ready` stays low until the final word is taken.
- R8: While the block is idle, input words without the start flag are accepted and discarded.
- R9: A word with the start flag that arrives while a packet is still being collected abandons that packet and is decoded as a new first word.
- R10: A synchronous active-high reset clears the word counter and forces `req_valid`, `pl_valid` and `req_malformed` low with `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | Input word is the first word of a packet |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Block accepts an input word this cycle |
| req_valid | output | 1 | Decoded request present |
| req_ready | input | 1 | Consumer takes the decoded request |
| req_kind | output | 2 | 0 read, 1 write, 2 erase, 3 other |
| req_type | output | 8 | Raw cycle type byte |
| req_tag | output | 4 | Request tag |
| req_len | output | 13 | Length in bytes (4096 for a zero-length read) |
| req_addr | output | 32 | Byte-order corrected address |
| req_pl_words | output | 5 | Number of payload words that follow the request |
| pl_valid | output | 1 | Payload word present |
| pl_ready | input | 1 | Consumer takes the payload word |
| pl_data | output | 32 | Payload word |
| pl_last | output | 1 | Payload word is the final one of the request |
| req_malformed | output | 1 | One-cycle pulse for an oversized write |

## Verification
The assertions check on every cycle that held requests and payload words stay stable and that the input stays stalled while anything is outstanding. They also check that lengths and payload counts stay in their legal ranges for each kind, and that a rejected write never coexists with a request. The values themselves can only be shown by the bench's scenarios. These include the field extraction and address byte reversal, the ceiling word count over every write length up to and past the limit, the zero-length read rule, stray-word discard and restart on a new start flag.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 13;
    localparam int NW_W   = 11;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_DATA   = 3'd2,
        ST_HOLD   = 3'd3,
        ST_STREAM = 3'd4
    } fcd_state_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_ERASE = 2'd2,
        KIND_OTHER = 2'd3
    } fcd_kind_e;

    function automatic fcd_kind_e kind_of(input logic [3:0] nib);
        case (nib)
            4'd0:    return KIND_READ;
            4'd1:    return KIND_WRITE;
            4'd2:    return KIND_ERASE;
            default: return KIND_OTHER;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] byte_reverse(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/fcd_hdr_parse.sv
module fcd_hdr_parse
    import fcd_pkg::*;
#(
    parameter int MAX_PL_WORDS = 16,
    parameter int CNT_W        = $clog2(MAX_PL_WORDS + 1)
) (
    input  logic [WORD_W-1:0] hdr,
    output logic [7:0]        typ,
    output fcd_kind_e         kind,
    output logic [3:0]        tag,
    output logic [LEN_W-1:0]  len,
    output logic [CNT_W-1:0]  pl_words,
    output logic              oversize
);
    localparam logic [NW_W-1:0] MAX_NW = NW_W'(MAX_PL_WORDS);

    logic [11:0]      raw_len;
    logic [LEN_W-1:0] rounded;
    logic [NW_W-1:0]  words_full;
    logic             is_write;

    always_comb begin
        typ      = hdr[15:8];
        tag      = hdr[23:20];
        raw_len  = {hdr[19:16], hdr[31:24]};
        kind     = kind_of(hdr[11:8]);
        is_write = (kind == KIND_WRITE);

        if (kind == KIND_READ && raw_len == 12'd0) begin
            len = LEN_W'(4096);
        end else begin
            len = {1'b0, raw_len};
        end

        rounded    = {1'b0, raw_len} + LEN_W'(3);
        words_full = rounded[LEN_W-1:2];
        oversize   = is_write && (words_full > MAX_NW);
        pl_words   = is_write ? words_full[CNT_W-1:0] : '0;
    end

endmodule

// File: rtl/fcd_pl_store.sv
module fcd_pl_store #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [DEPTH-1:0][WIDTH-1:0] slots;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [WIDTH-1:0] word_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(g)) begin
                word_q <= wr_data;
            end
        end
        assign slots[g] = word_q;
    end

    assign rd_data = slots[rd_idx];

endmodule

// File: rtl/flash_req_decoder.sv
module flash_req_decoder
    import fcd_pkg::*;
#(
    parameter int MAX_PL_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        req_valid,
    input  logic        req_ready,
    output logic [1:0]  req_kind,
    output logic [7:0]  req_type,
    output logic [3:0]  req_tag,
    output logic [12:0] req_len,
    output logic [31:0] req_addr,
    output logic [4:0]  req_pl_words,
    output logic        pl_valid,
    input  logic        pl_ready,
    output logic [31:0] pl_data,
    output logic        pl_last,
    output logic        req_malformed
);
    localparam int CNT_W = $clog2(MAX_PL_WORDS + 1);
    localparam int IDX_W = $clog2(MAX_PL_WORDS);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        fcd_state_e       st;
        logic [7:0]       typ;
        fcd_kind_e        kind;
        logic [3:0]       tag;
        logic [LEN_W-1:0] len;
        logic [31:0]      addr;
        logic [CNT_W-1:0] nw;
        logic [CNT_W-1:0] cnt;
        logic             bad;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st:   ST_IDLE,
        typ:  '0,
        kind: KIND_READ,
        tag:  '0,
        len:  '0,
        addr: '0,
        nw:   '0,
        cnt:  '0,
        bad:  1'b0
    };

    regs_t r_q, r_d;

    logic [7:0]       p_typ;
    fcd_kind_e        p_kind;
    logic [3:0]       p_tag;
    logic [LEN_W-1:0] p_len;
    logic [CNT_W-1:0] p_nw;
    logic             p_oversize;

    fcd_hdr_parse #(
        .MAX_PL_WORDS (MAX_PL_WORDS),
        .CNT_W        (CNT_W)
    ) u_parse (
        .hdr      (in_data),
        .typ      (p_typ),
        .kind     (p_kind),
        .tag      (p_tag),
        .len      (p_len),
        .pl_words (p_nw),
        .oversize (p_oversize)
    );

    logic             st_wr_en;
    logic [31:0]      st_rd_data;

    fcd_pl_store #(
        .DEPTH (MAX_PL_WORDS),
        .WIDTH (WORD_W),
        .IDX_W (IDX_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (st_wr_en),
        .wr_idx  (r_q.cnt[IDX_W-1:0]),
        .wr_data (in_data),
        .rd_idx  (r_q.cnt[IDX_W-1:0]),
        .rd_data (st_rd_data)
    );

    logic collecting;
    logic last_word;

    always_comb begin
        collecting = (r_q.st == ST_IDLE) || (r_q.st == ST_ADDR) || (r_q.st == ST_DATA);
        last_word  = ((r_q.cnt + ONE) == r_q.nw);
        st_wr_en   = (r_q.st == ST_DATA) && in_valid && !in_sop;

        r_d     = r_q;
        r_d.bad = 1'b0;

        case (r_q.st)
            ST_IDLE, ST_ADDR, ST_DATA: begin
                if (in_valid && in_sop) begin
                    r_d.typ  = p_typ;
                    r_d.kind = p_kind;
                    r_d.tag  = p_tag;
                    r_d.len  = p_len;
                    r_d.nw   = p_nw;
                    r_d.cnt  = '0;
                    if (p_oversize) begin
                        r_d.bad = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.st  = ST_ADDR;
                    end
                end else if (in_valid) begin
                    if (r_q.st == ST_ADDR) begin
                        r_d.addr = byte_reverse(in_data);
                        r_d.cnt  = '0;
                        if (r_q.nw != '0) begin
                            r_d.st = ST_DATA;
                        end else begin
                            r_d.st = ST_HOLD;
                        end
                    end else if (r_q.st == ST_DATA) begin
                        if (last_word) begin
                            r_d.cnt = '0;
                            r_d.st  = ST_HOLD;
                        end else begin
                            r_d.cnt = r_q.cnt + ONE;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (req_ready) begin
                    r_d.cnt = '0;
                    if (r_q.nw != '0) begin
                        r_d.st = ST_STREAM;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_STREAM: begin
                if (pl_ready) begin
                    if (last_word) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + ONE;
                    end
                end
            end
            default: begin
                r_d = RESET_VAL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready      = collecting;
    assign req_valid     = (r_q.st == ST_HOLD);
    assign req_kind      = r_q.kind;
    assign req_type      = r_q.typ;
    assign req_tag       = r_q.tag;
    assign req_len       = r_q.len;
    assign req_addr      = r_q.addr;
    assign req_pl_words  = 5'(r_q.nw);
    assign pl_valid      = (r_q.st == ST_STREAM);
    assign pl_data       = st_rd_data;
    assign pl_last       = pl_valid && last_word;
    assign req_malformed = r_q.bad;

endmodule

// File: rtl/flash_req_decoder_chk.sv
module flash_req_decoder_chk #(
    parameter int MAX_PL_WORDS = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_kind,
    input logic [7:0]  req_type,
    input logic [3:0]  req_tag,
    input logic [12:0] req_len,
    input logic [31:0] req_addr,
    input logic [4:0]  req_pl_words,
    input logic        pl_valid,
    input logic        pl_ready,
    input logic [31:0] pl_data,
    input logic        pl_last,
    input logic        req_malformed
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len)
        && $stable(req_tag) && $stable(req_type) && $stable(req_kind) && $stable(req_pl_words)); // R6

    AST_STALL_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_valid || pl_valid) |-> !in_ready); // R6

    AST_PL_STABLE: assert property (@(posedge clk) disable iff (rst)
        pl_valid && !pl_ready |=> pl_valid && $stable(pl_data) && $stable(pl_last)); // R7

    AST_PL_END: assert property (@(posedge clk) disable iff (rst)
        pl_valid && pl_ready && pl_last |=> !pl_valid && in_ready); // R7

    AST_NONWRITE_NO_PL: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind != 2'd1 |-> req_pl_words == 5'd0); // R4

    AST_PL_BOUND: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_pl_words <= 5'(MAX_PL_WORDS)); // R5

    AST_READ_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == 2'd0 |-> req_len != 13'd0); // R2

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind != 2'd0 |-> !req_len[12]); // R2

    AST_BAD_NOT_FORWARDED: assert property (@(posedge clk) disable iff (rst)
        req_malformed |-> !req_valid && !pl_valid && in_ready); // R5

    AST_BAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        req_malformed |=> !req_malformed || in_ready); // R5

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> !req_valid && !pl_valid && !req_malformed && in_ready); // R10

endmodule

bind flash_req_decoder flash_req_decoder_chk #(.MAX_PL_WORDS(MAX_PL_WORDS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_ready      (in_ready),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_kind      (req_kind),
    .req_type      (req_type),
    .req_tag       (req_tag),
    .req_len       (req_len),
    .req_addr      (req_addr),
    .req_pl_words  (req_pl_words),
    .pl_valid      (pl_valid),
    .pl_ready      (pl_ready),
    .pl_data       (pl_data),
    .pl_last       (pl_last),
    .req_malformed (req_malformed)
);

// File: tb/flash_req_decoder_tb.sv
module flash_req_decoder_tb;
    localparam int MAXW = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sop;
    logic [31:0] in_data;
    logic        in_ready;
    logic        req_valid, req_ready;
    logic [1:0]  req_kind;
    logic [7:0]  req_type;
    logic [3:0]  req_tag;
    logic [12:0] req_len;
    logic [31:0] req_addr;
    logic [4:0]  req_pl_words;
    logic        pl_valid, pl_ready, pl_last, req_malformed;
    logic [31:0] pl_data;

    int errs   = 0;
    int checks = 0;

    always #10 clk = ~clk;

    flash_req_decoder #(.MAX_PL_WORDS(MAXW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .in_ready(in_ready), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_type(req_type), .req_tag(req_tag), .req_len(req_len),
        .req_addr(req_addr), .req_pl_words(req_pl_words), .pl_valid(pl_valid),
        .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
        .req_malformed(req_malformed)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] pword(input int len, input int i);
        return 32'h5A00_0000 ^ 32'(len << 12) ^ 32'(i * 32'h0101);
    endfunction

    function automatic logic [31:0] swap(input logic [31:0] a);
        return {a[7:0], a[15:8], a[23:16], a[31:24]};
    endfunction

    task automatic send(input logic [31:0] d, input logic s);
        in_valid = 1'b1;
        in_data  = d;
        in_sop   = s;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic wait_req();
        for (int t = 0; t < 20 && !req_valid; t++) @(negedge clk);
    endtask

    task automatic do_req(input logic [7:0] typ, input logic [3:0] tag, input int len,
                          input logic [31:0] addr);
        int  nib   = int'(typ[3:0]);
        bit  wr    = (nib == 1);
        int  nw    = wr ? (len + 3) / 4 : 0;
        bit  bad   = wr && (nw > MAXW);
        int  elen  = (nib == 0 && len == 0) ? 4096 : len;
        int  ekind = (nib <= 2) ? nib : 3;
        logic [11:0] l12 = 12'(len);

        send({l12[7:0], tag, l12[11:8], typ, 8'hC3}, 1'b1);
        if (bad) begin
            check("R5 malformed flag", 32'(req_malformed), 1);
            send(swap(addr), 1'b0);
            check("R5 flag lasts one cycle", 32'(req_malformed), 0);
            for (int i = 0; i < 3; i++) send(pword(len, i), 1'b0);
            repeat (2) @(negedge clk);
            check("R5 no request forwarded", 32'(req_valid), 0);
            check("R5 input still open", 32'(in_ready), 1);
            return;
        end
        send(swap(addr), 1'b0);
        for (int i = 0; i < nw; i++) send(pword(len, i), 1'b0);
        wait_req();
        check("R1 request present", 32'(req_valid), 1);
        check("R1 kind", 32'(req_kind), 32'(ekind));
        check("R1 type byte", 32'(req_type), 32'(typ));
        check("R1 tag", 32'(req_tag), 32'(tag));
        check("R2 length", 32'(req_len), 32'(elen));
        check("R3 address", req_addr, addr);
        check("R4 payload count", 32'(req_pl_words), 32'(nw));
        repeat (2) begin
            @(negedge clk);
            check("R6 held valid", 32'(req_valid), 1);
            check("R6 held address", req_addr, addr);
            check("R6 held length", 32'(req_len), 32'(elen));
            check("R6 input stalled", 32'(in_ready), 0);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        check("R6 request released", 32'(req_valid), 0);
        for (int i = 0; i < nw; i++) begin
            for (int t = 0; t < 10 && !pl_valid; t++) @(negedge clk);
            check("R7 payload valid", 32'(pl_valid), 1);
            check("R7 payload word", pl_data, pword(len, i));
            check("R7 last flag", 32'(pl_last), 32'(i == nw - 1));
            check("R7 input stalled", 32'(in_ready), 0);
            if (i == 0) begin
                @(negedge clk);
                check("R7 payload held", pl_data, pword(len, i));
            end
            pl_ready = 1'b1;
            @(negedge clk);
            pl_ready = 1'b0;
        end
        check("R4 no payload after end", 32'(pl_valid), 0);
        check("R4 input reopened", 32'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0; in_data = '0;
        req_ready = 1'b0; pl_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset req_valid", 32'(req_valid), 0);
        check("R10 reset pl_valid", 32'(pl_valid), 0);
        check("R10 reset malformed", 32'(req_malformed), 0);
        check("R10 reset in_ready", 32'(in_ready), 1);

        // writes over every length up to and past the store limit (R4, R5)
        for (int l = 0; l <= 70; l++) begin
            do_req(8'h01, 4'(l), l, 32'h1000_0000 + 32'(l * 4));
        end
        do_req(8'hF1, 4'hE, 12, 32'hDEAD_BEEF);   // R1 upper type nibble ignored for kind
        do_req(8'h01, 4'h3, 4095, 32'h0);          // R5 largest oversize

        // reads including zero length (R2)
        do_req(8'h00, 4'h1, 0, 32'h0012_3456);
        do_req(8'h00, 4'h2, 1, 32'h89AB_CDEF);
        do_req(8'h00, 4'h3, 64, 32'h0000_0040);
        do_req(8'h00, 4'h4, 2048, 32'h7F00_0001);
        do_req(8'h00, 4'hF, 4095, 32'hFFFF_F000);

        // erase with zero length stays zero (R2)
        do_req(8'h02, 4'h5, 0, 32'h0001_0000);
        do_req(8'h02, 4'h6, 4095, 32'h0002_0000);

        // other kinds (R1)
        for (int n = 3; n < 16; n++) begin
            do_req({4'h6, 4'(n)}, 4'(n), 5 + n, 32'hA000_0000 + 32'(n));
        end

        // stray words while idle are discarded (R8)
        for (int i = 0; i < 3; i++) send(32'h1111_0000 + 32'(i), 1'b0);
        @(negedge clk);
        check("R8 stray words ignored", 32'(req_valid), 0);
        check("R8 input open", 32'(in_ready), 1);
        do_req(8'h00, 4'h9, 8, 32'h0BAD_F00D);

        // start flag mid-packet restarts (R9)
        send({8'd8, 4'h7, 4'h0, 8'h01, 8'h00}, 1'b1);
        send(swap(32'h5555_5555), 1'b0);
        send(32'h2222_2222, 1'b0);
        check("R9 partial write not forwarded", 32'(req_valid), 0);
        do_req(8'h00, 4'hA, 16, 32'h0C0F_FEE0);
        send({8'd4, 4'h7, 4'h0, 8'h02, 8'h00}, 1'b1);
        do_req(8'h01, 4'hB, 8, 32'h0000_1234);

        // reset while a request is held (R10)
        send({8'd4, 4'h1, 4'h0, 8'h00, 8'h00}, 1'b1);
        send(32'h0, 1'b0);
        wait_req();
        check("R10 request before reset", 32'(req_valid), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset drops request", 32'(req_valid), 0);
        check("R10 reset reopens input", 32'(in_ready), 1);
        do_req(8'h01, 4'h2, 20, 32'h4444_0000);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule